// File: doc/BRIEF.md
# Serial Register Port for a Measurement Converter

This block is the host-facing register port of a measurement converter. An SPI-style slave (clock idles high, input sampled on the rising clock edge, output changed after the falling edge) gives access to eight registers. Three of them are read-only: status, conversion result and identity. Five are writable: mode, configuration, pin control, offset and gain. The serial inputs are resampled into the system clock domain, so the serial clock must be slow against the system clock. The output pin carries register data during a read. At all other times while the chip select is low it shows the active-low ready bit, so a host can wait for a result without polling.

Results from the conversion engine enter through a valid/ready stream that carries the result word, a channel code, an error flag and a missing-reference flag. A word is taken on any cycle where valid and ready are both high. Ready is low from the end of a command byte that reads the result register until that read completes or is aborted. The engine must hold its word and valid until ready returns, so the word being shifted out is never replaced during the read. A read of the result register can carry the status byte after the result. A parity flag reports whether the result has an odd number of ones. Offset and gain take writes only while the engine is stopped.

Top module: `spi_reg_port`

## Requirements
- R1: After reset the registers read: status 0x80, mode 0x080060, configuration 0x000117, result 0x000000, identity = parameter `ID_VALUE` with its low nibble 0, pin control 0x00, offset 0x800000, gain 0x555555. The mode and configuration words are also presented on output ports.
- R2: The first byte of a frame is a command. Bit 7 and bits 2:0 must be 0, bit 6 selects a read (1) or a write (0), and bits 5:3 give the address: 0 status, 1 mode, 2 configuration, 3 result, 4 identity, 5 pin control, 6 offset, 7 gain. Addresses 0, 4 and 5 take one data byte and the others three bytes, most significant first. A command byte with a reserved bit set is dropped, and the next byte is taken as a new command.
- R3: `spi_miso_oe` is 1 exactly while the chip select is low. Frames may follow one another with the chip select held low.
- R4: While the chip select is low and no read data is being shifted, `spi_miso` equals the ready bit (0 means a result is waiting).
- R5: An accepted result sets status to {ready=0, error, no-reference, parity, channel[3:0]} in bits 7..0 and loads the result register.
- R6: `res_ready` is 0 from the end of a result-register read command until that read completes or the chip select rises. A result held during that time is taken afterwards, and the read returns the old word.
- R7: The ready bit returns to 1 only after every byte of a result-register read has been shifted. An aborted read leaves it at 0.
- R8: When mode bit 20 is 1, a result-register read shifts 4 bytes: the result, then the status byte as it stood when the command ended.
- R9: When mode bit 13 is 1, status bit 4 is 1 exactly when the result word has an odd number of ones. Otherwise it reads 0.
- R10: Offset and gain writes take effect only while mode bits 23:21 are 010 (idle) or 011 (sleep). They can be read at any time.
- R11: In the pin control register, bit 5 enables pins 3:2 and bit 4 enables pins 1:0 as outputs, bits 3:0 give the output levels, bit 6 drives `bridge_sw`, and bit 7 always reads 0. A readback returns the pin levels for an enabled pair and the stored bits for a disabled pair.
- R12: A write frame whose chip select rises before the last data byte leaves the register unchanged.
- R13: Writes to the status, result and identity addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idles high |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out / ready indicator |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` |
| res_valid | input | 1 | Result stream valid |
| res_ready | output | 1 | Result stream ready |
| res_data | input | 24 | Result word |
| res_chan | input | 4 | Channel code of the result |
| res_err | input | 1 | Error flag of the result |
| res_noref | input | 1 | Missing-reference flag of the result |
| gpio_in | input | 4 | Pin levels for readback |
| gpio_out | output | 4 | Pin output levels |
| gpio_oe | output | 4 | Pin output enables |
| bridge_sw | output | 1 | Bridge switch control |
| mode_word | output | 24 | Current mode register |
| cfg_word | output | 24 | Current configuration register |

## Verification
Register frames are run with each address and with both frame lengths. The same frames are repeated with malformed command bytes and with the chip select rising in mid-frame. This separates correct byte counting and command decoding from frames that run one byte out of step. Results are pushed with the port idle, during a read of the result register, with the status append on and off, and with result words of odd and even bit count. These cases separate the ready handshake, the parity flag and back-pressure from one another. Offset and gain writes are made under four mode settings, and pin-control writes under each enable pattern, to show that the gating and the readback paths are independent.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int BYTE_W  = 8;
  localparam int REG_W   = 24;
  localparam int WORD_W  = REG_W + BYTE_W;
  localparam int ADDR_W  = 3;
  localparam int N_PAIRS = 2;
  localparam int PIN_W   = 2 * N_PAIRS;

  localparam logic [ADDR_W-1:0] ADDR_STAT  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_MODE  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CONF  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_DATA  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_IDENT = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_PINS  = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_OFFS  = 3'd6;
  localparam logic [ADDR_W-1:0] ADDR_GAIN  = 3'd7;

  localparam logic [REG_W-1:0] MODE_RST = 24'h080060;
  localparam logic [REG_W-1:0] CONF_RST = 24'h000117;
  localparam logic [REG_W-1:0] OFFS_RST = 24'h800000;
  localparam logic [REG_W-1:0] GAIN_RST = 24'h555555;

  localparam int APPEND_BIT = 20;
  localparam int PARITY_BIT = 13;
  localparam int MD_HI      = 23;
  localparam int MD_LO      = 21;
  localparam int BRIDGE_BIT = 6;
  localparam int PAIR_EN_LO = 4;

  localparam logic [2:0] MD_IDLE  = 3'b010;
  localparam logic [2:0] MD_SLEEP = 3'b011;

  typedef enum logic [1:0] {PH_CMD, PH_WR, PH_RD} phase_e;

  function automatic logic [2:0] reg_len(input logic [ADDR_W-1:0] a);
    case (a)
      ADDR_STAT, ADDR_IDENT, ADDR_PINS: return 3'd1;
      default:                          return 3'd3;
    endcase
  endfunction
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_raw,
  input  logic cs_n_raw,
  input  logic mosi_raw,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic mosi_s
);
  // bit 0 serial clock, bit 1 chip select, bit 2 data in
  localparam logic [2:0] IDLE_LVL = 3'b011;

  logic [2:0] stage_q [SYNC_STAGES];
  logic       sclk_prev_q;
  logic [2:0] last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) stage_q[i] <= IDLE_LVL;
      sclk_prev_q <= 1'b1;
    end else begin
      stage_q[0] <= {mosi_raw, cs_n_raw, sclk_raw};
      for (int i = 1; i < SYNC_STAGES; i++) stage_q[i] <= stage_q[i-1];
      sclk_prev_q <= stage_q[SYNC_STAGES-1][0];
    end
  end

  assign last      = stage_q[SYNC_STAGES-1];
  assign sclk_rise = last[0] & ~sclk_prev_q;
  assign sclk_fall = ~last[0] & sclk_prev_q;
  assign cs_act    = ~last[1];
  assign mosi_s    = last[2];
endmodule

// File: rtl/spi_frame_ctl.sv
module spi_frame_ctl
  import spi_reg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sclk_rise,
  input  logic                     sclk_fall,
  input  logic                     cs_act,
  input  logic                     mosi_s,
  input  logic                     append_en,
  input  logic [WORD_W-1:0]        rd_word,
  output logic [ADDR_W-1:0]        acc_addr,
  output logic                     rd_busy,
  output logic                     rd_done,
  output logic                     wr_stb,
  output logic [REG_W-1:0]         wr_data,
  output logic                     drive_data,
  output logic                     miso_bit
);
  phase_e              phase_q;
  logic [2:0]          bit_cnt_q;
  logic [BYTE_W-1:0]   rx_q;
  logic [BYTE_W-1:0]   rx_next;
  logic [2:0]          left_q;
  logic [2:0]          cmd_len;
  logic [ADDR_W-1:0]   addr_q;
  logic [REG_W-1:0]    acc_q;
  logic [WORD_W-1:0]   tx_q;
  logic                load_q;
  logic                drive_q;
  logic                miso_q;
  logic                cmd_ok;

  assign rx_next = {rx_q[BYTE_W-2:0], mosi_s};
  assign cmd_ok  = (rx_next[7] == 1'b0) && (rx_next[2:0] == 3'b000);
  assign cmd_len = reg_len(rx_next[5:3]) +
                   ((rx_next[6] && rx_next[5:3] == ADDR_DATA && append_en) ? 3'd1 : 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_CMD;
      bit_cnt_q <= '0;
      rx_q      <= '0;
      left_q    <= '0;
      addr_q    <= '0;
      acc_q     <= '0;
      tx_q      <= '0;
      load_q    <= 1'b0;
      drive_q   <= 1'b0;
      miso_q    <= 1'b1;
      wr_stb    <= 1'b0;
      wr_data   <= '0;
      rd_done   <= 1'b0;
    end else begin
      wr_stb  <= 1'b0;
      rd_done <= 1'b0;
      if (!cs_act) begin
        phase_q   <= PH_CMD;
        bit_cnt_q <= '0;
        load_q    <= 1'b0;
        drive_q   <= 1'b0;
      end else begin
        if (load_q) begin
          tx_q   <= rd_word;
          load_q <= 1'b0;
        end
        if (sclk_fall && phase_q == PH_RD && !load_q) begin
          miso_q  <= tx_q[WORD_W-1];
          tx_q    <= {tx_q[WORD_W-2:0], 1'b0};
          drive_q <= 1'b1;
        end
        if (sclk_rise) begin
          rx_q      <= rx_next;
          bit_cnt_q <= bit_cnt_q + 3'd1;
          if (bit_cnt_q == 3'd7) begin
            case (phase_q)
              PH_CMD: begin
                if (cmd_ok) begin
                  addr_q  <= rx_next[5:3];
                  left_q  <= cmd_len;
                  acc_q   <= '0;
                  phase_q <= rx_next[6] ? PH_RD : PH_WR;
                  load_q  <= rx_next[6];
                end
              end
              PH_WR: begin
                acc_q  <= {acc_q[REG_W-BYTE_W-1:0], rx_next};
                left_q <= left_q - 3'd1;
                if (left_q == 3'd1) begin
                  wr_stb  <= 1'b1;
                  wr_data <= {acc_q[REG_W-BYTE_W-1:0], rx_next};
                  phase_q <= PH_CMD;
                end
              end
              PH_RD: begin
                left_q <= left_q - 3'd1;
                if (left_q == 3'd1) begin
                  rd_done <= 1'b1;
                  drive_q <= 1'b0;
                  phase_q <= PH_CMD;
                end
              end
              default: phase_q <= PH_CMD;
            endcase
          end
        end
      end
    end
  end

  assign acc_addr   = addr_q;
  assign rd_busy    = (phase_q == PH_RD);
  assign drive_data = drive_q;
  assign miso_bit   = miso_q;

  // R4: read data replaces the ready bit only inside a read data phase
  assert_drive_in_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    drive_q |-> (phase_q == PH_RD));

  // R12: a register write is only committed from inside a live frame
  assert_write_in_frame_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(cs_act));
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_reg_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ID_VALUE = 8'h50
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_stb,
  input  logic [REG_W-1:0]     wr_data,
  input  logic [ADDR_W-1:0]    acc_addr,
  input  logic                 rd_busy,
  input  logic                 rd_done,
  input  logic                 res_valid,
  output logic                 res_ready,
  input  logic [REG_W-1:0]     res_data,
  input  logic [3:0]           res_chan,
  input  logic                 res_err,
  input  logic                 res_noref,
  input  logic [PIN_W-1:0]     gpio_in,
  output logic [PIN_W-1:0]     gpio_out,
  output logic [PIN_W-1:0]     gpio_oe,
  output logic                 bridge_sw,
  output logic                 drdy_n,
  output logic                 append_en,
  output logic [WORD_W-1:0]    rd_word,
  output logic [REG_W-1:0]     mode_word,
  output logic [REG_W-1:0]     cfg_word
);
  logic [REG_W-1:0]  mode_q, conf_q, data_q, offs_q, gain_q;
  logic [BYTE_W-1:0] pins_q, pins_rb, status;
  logic              drdy_q, err_q, noref_q;
  logic [3:0]        chan_q;
  logic              parity;
  logic              accept;
  logic              cal_ok;
  logic              data_rd_end;

  assign res_ready   = !(rd_busy && acc_addr == ADDR_DATA);
  assign accept      = res_valid && res_ready;
  assign parity      = mode_q[PARITY_BIT] & (^data_q);
  assign status      = {drdy_q, err_q, noref_q, parity, chan_q};
  assign cal_ok      = (mode_q[MD_HI:MD_LO] == MD_IDLE) || (mode_q[MD_HI:MD_LO] == MD_SLEEP);
  assign data_rd_end = rd_done && acc_addr == ADDR_DATA;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drdy_q  <= 1'b1;
      err_q   <= 1'b0;
      noref_q <= 1'b0;
      chan_q  <= '0;
      data_q  <= '0;
    end else if (accept) begin
      drdy_q  <= 1'b0;
      err_q   <= res_err;
      noref_q <= res_noref;
      chan_q  <= res_chan;
      data_q  <= res_data;
    end else if (data_rd_end) begin
      drdy_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
      conf_q <= CONF_RST;
      pins_q <= '0;
      offs_q <= OFFS_RST;
      gain_q <= GAIN_RST;
    end else if (wr_stb) begin
      case (acc_addr)
        ADDR_MODE: mode_q <= wr_data;
        ADDR_CONF: conf_q <= wr_data;
        ADDR_PINS: pins_q <= {1'b0, wr_data[BYTE_W-2:0]};
        ADDR_OFFS: if (cal_ok) offs_q <= wr_data;
        ADDR_GAIN: if (cal_ok) gain_q <= wr_data;
        default: ;
      endcase
    end
  end

  // one enable bit per pin pair; readback follows the pins when enabled
  for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
    assign gpio_oe[2*p +: 2] = {2{pins_q[PAIR_EN_LO + p]}};
    assign pins_rb[2*p +: 2] = pins_q[PAIR_EN_LO + p] ? gpio_in[2*p +: 2] : pins_q[2*p +: 2];
  end
  assign pins_rb[BYTE_W-1:PIN_W] = pins_q[BYTE_W-1:PIN_W];

  assign gpio_out  = pins_q[PIN_W-1:0];
  assign bridge_sw = pins_q[BRIDGE_BIT];
  assign drdy_n    = drdy_q;
  assign append_en = mode_q[APPEND_BIT];
  assign mode_word = mode_q;
  assign cfg_word  = conf_q;

  always_comb begin
    case (acc_addr)
      ADDR_STAT:  rd_word = {status, {REG_W{1'b0}}};
      ADDR_MODE:  rd_word = {mode_q, {BYTE_W{1'b0}}};
      ADDR_CONF:  rd_word = {conf_q, {BYTE_W{1'b0}}};
      ADDR_DATA:  rd_word = {data_q, status};
      ADDR_IDENT: rd_word = {ID_VALUE[7:4], 4'b0000, {REG_W{1'b0}}};
      ADDR_PINS:  rd_word = {pins_rb, {REG_W{1'b0}}};
      ADDR_OFFS:  rd_word = {offs_q, {BYTE_W{1'b0}}};
      default:    rd_word = {gain_q, {BYTE_W{1'b0}}};
    endcase
  end

  // R10: calibration words only change while the mode field says idle or sleep
  assert_offset_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (offs_q != $past(offs_q)) |-> ($past(mode_q[MD_HI:MD_LO]) == MD_IDLE || $past(mode_q[MD_HI:MD_LO]) == MD_SLEEP));

  assert_gain_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_q != $past(gain_q)) |-> ($past(mode_q[MD_HI:MD_LO]) == MD_IDLE || $past(mode_q[MD_HI:MD_LO]) == MD_SLEEP));

  // R5: ready bit drops only on a stream handshake
  assert_ready_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drdy_q) |-> $past(res_valid && res_ready));

  // R6: the result word stays put while it is being shifted out
  assert_hold_during_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_busy && acc_addr == ADDR_DATA) |=> $stable(data_q));

  // R7: ready bit returns only after a completed result read
  assert_ready_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drdy_q) |-> $past(rd_done && acc_addr == ADDR_DATA));
endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port
  import spi_reg_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] ID_VALUE    = 8'h50
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                spi_sclk,
  input  logic                spi_cs_n,
  input  logic                spi_mosi,
  output logic                spi_miso,
  output logic                spi_miso_oe,
  input  logic                res_valid,
  output logic                res_ready,
  input  logic [REG_W-1:0]    res_data,
  input  logic [3:0]          res_chan,
  input  logic                res_err,
  input  logic                res_noref,
  input  logic [PIN_W-1:0]    gpio_in,
  output logic [PIN_W-1:0]    gpio_out,
  output logic [PIN_W-1:0]    gpio_oe,
  output logic                bridge_sw,
  output logic [REG_W-1:0]    mode_word,
  output logic [REG_W-1:0]    cfg_word
);
  logic                sclk_rise, sclk_fall, cs_act, mosi_s;
  logic                append_en, rd_busy, rd_done, wr_stb;
  logic                drive_data, miso_bit, drdy_n;
  logic [ADDR_W-1:0]   acc_addr;
  logic [REG_W-1:0]    wr_data;
  logic [WORD_W-1:0]   rd_word;

  spi_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .sclk_raw(spi_sclk), .cs_n_raw(spi_cs_n), .mosi_raw(spi_mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act), .mosi_s(mosi_s)
  );

  spi_frame_ctl u_frame (
    .clk(clk), .rst_n(rst_n),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act), .mosi_s(mosi_s),
    .append_en(append_en), .rd_word(rd_word),
    .acc_addr(acc_addr), .rd_busy(rd_busy), .rd_done(rd_done),
    .wr_stb(wr_stb), .wr_data(wr_data),
    .drive_data(drive_data), .miso_bit(miso_bit)
  );

  spi_reg_bank #(.ID_VALUE(ID_VALUE)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_stb(wr_stb), .wr_data(wr_data), .acc_addr(acc_addr),
    .rd_busy(rd_busy), .rd_done(rd_done),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_chan(res_chan), .res_err(res_err), .res_noref(res_noref),
    .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe), .bridge_sw(bridge_sw),
    .drdy_n(drdy_n), .append_en(append_en), .rd_word(rd_word),
    .mode_word(mode_word), .cfg_word(cfg_word)
  );

  assign spi_miso    = drive_data ? miso_bit : drdy_n;
  assign spi_miso_oe = cs_act;

  // R3: the output is released within the sync delay of chip select rising
  assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act && !$past(cs_act)) |-> (!spi_miso_oe && !drive_data));
endmodule

// File: tb/spi_reg_port_test.sv
module spi_reg_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8 * CLK_PERIOD;
  localparam logic [7:0] ID_EXP = 8'h50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sclk = 1'b1, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe;
  logic res_valid = 1'b0;
  logic res_ready;
  logic [23:0] res_data = '0;
  logic [3:0]  res_chan = '0;
  logic res_err = 1'b0, res_noref = 1'b0;
  logic [3:0] gpio_in = '0;
  logic [3:0] gpio_out, gpio_oe;
  logic bridge_sw;
  logic [23:0] mode_word, cfg_word;

  int n_chk = 0;
  int n_bad = 0;

  spi_reg_port #(.ID_VALUE(ID_EXP)) uut (
    .clk(clk), .rst_n(rst_n),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_chan(res_chan), .res_err(res_err), .res_noref(res_noref),
    .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe), .bridge_sw(bridge_sw),
    .mode_word(mode_word), .cfg_word(cfg_word)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      spi_sclk = 1'b0;
      spi_mosi = tx[i];
      #HALF;
      rx[i] = spi_miso;
      spi_sclk = 1'b1;
      #HALF;
    end
  endtask

  task automatic cs_low();
    spi_cs_n = 1'b0;
    #HALF;
  endtask

  task automatic cs_high();
    #HALF;
    spi_cs_n = 1'b1;
    #(4*HALF);
  endtask

  task automatic xfer(input logic [7:0] cmd, input int nb, input logic [31:0] wd,
                      output logic [31:0] rd);
    logic [7:0] r;
    rd = '0;
    cs_low();
    spi_byte(cmd, r);
    for (int b = 0; b < nb; b++) begin
      spi_byte(8'((wd >> (8*(nb-1-b)))), r);
      rd = {rd[23:0], r};
    end
    cs_high();
  endtask

  function automatic logic [7:0] rcmd(input int a); return 8'h40 | 8'(a << 3); endfunction
  function automatic logic [7:0] wcmd(input int a); return 8'(a << 3); endfunction

  task automatic rd_reg(input int a, input int nb, output logic [31:0] v);
    xfer(rcmd(a), nb, 32'h0, v);
  endtask

  task automatic wr_reg(input int a, input int nb, input logic [31:0] v);
    logic [31:0] dummy;
    xfer(wcmd(a), nb, v, dummy);
  endtask

  task automatic push(input logic [23:0] d, input logic [3:0] ch, input logic e, input logic nr);
    res_data = d; res_chan = ch; res_err = e; res_noref = nr;
    res_valid = 1'b1;
    while (!res_ready) begin @(posedge clk); #2; end
    @(posedge clk); #2;
    res_valid = 1'b0;
    #(4*CLK_PERIOD);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R3 oe idle", 32'(spi_miso_oe), 0);
    check("R6 ready idle", 32'(res_ready), 1);
    check("R1 mode port", 32'(mode_word), 32'h080060);
    check("R1 cfg port", 32'(cfg_word), 32'h000117);
    check("R11 oe reset", 32'(gpio_oe), 0);
    rd_reg(0, 1, v); check("R1 status", v, 32'h80);
    rd_reg(1, 3, v); check("R1 mode", v, 32'h080060);
    rd_reg(2, 3, v); check("R1 config", v, 32'h000117);
    rd_reg(3, 3, v); check("R1 data", v, 32'h000000);
    rd_reg(4, 1, v); check("R1 ident", v, 32'(ID_EXP));
    rd_reg(5, 1, v); check("R1 pins", v, 32'h00);
    rd_reg(6, 3, v); check("R1 offset", v, 32'h800000);
    rd_reg(7, 3, v); check("R1 gain", v, 32'h555555);
    wr_reg(2, 3, 32'h000005);
    check("R2 cfg port write", 32'(cfg_word), 32'h000005);
    rd_reg(2, 3, v); check("R2 cfg readback", v, 32'h000005);
  endtask

  task automatic t_ready_pin();
    logic [31:0] v;
    cs_low();
    #(10*CLK_PERIOD);
    check("R3 oe low cs", 32'(spi_miso_oe), 1);
    check("R4 pin no result", 32'(spi_miso), 1);
    push(24'h123456, 4'h3, 1'b0, 1'b1);
    check("R4 pin result waiting", 32'(spi_miso), 0);
    cs_high();
    rd_reg(0, 1, v); check("R5 status fields", v, 32'h23);
    rd_reg(3, 3, v); check("R5 data word", v, 32'h123456);
    rd_reg(0, 1, v); check("R7 ready after read", v, 32'hA3);
  endtask

  task automatic t_abort_read();
    logic [31:0] v;
    logic [7:0] r;
    push(24'h0000AA, 4'h1, 1'b0, 1'b0);
    cs_low();
    spi_byte(rcmd(3), r);
    spi_byte(8'h00, r);
    cs_high();
    check("R6 ready after abort", 32'(res_ready), 1);
    rd_reg(0, 1, v); check("R7 aborted read keeps ready low", v, 32'h01);
  endtask

  task automatic t_backpressure();
    logic [31:0] v;
    logic [7:0] r;
    int waited;
    cs_low();
    spi_byte(rcmd(3), r);
    #(4*CLK_PERIOD);
    check("R6 ready low in read", 32'(res_ready), 0);
    res_data = 24'h654321; res_chan = 4'h2; res_err = 1'b1; res_noref = 1'b0;
    res_valid = 1'b1;
    #(20*CLK_PERIOD);
    check("R6 still held", 32'(res_ready), 0);
    v = '0;
    for (int b = 0; b < 3; b++) begin spi_byte(8'h00, r); v = {v[23:0], r}; end
    check("R6 old word returned", v, 32'h0000AA);
    cs_high();
    waited = 0;
    while (!res_ready) begin @(posedge clk); #2; waited++; end
    @(posedge clk); #2;
    res_valid = 1'b0;
    #(4*CLK_PERIOD);
    rd_reg(3, 3, v); check("R6 held word taken", v, 32'h654321);
    rd_reg(0, 1, v); check("R5 error flag", v, 32'hC2);
  endtask

  task automatic t_bad_cmd();
    logic [31:0] v;
    logic [7:0] r;
    cs_low();
    spi_byte(8'h51, r);
    spi_byte(rcmd(2), r);
    v = '0;
    for (int b = 0; b < 3; b++) begin spi_byte(8'h00, r); v = {v[23:0], r}; end
    check("R2 reserved low bit dropped", v, 32'h000005);
    spi_byte(8'hE0, r);
    spi_byte(rcmd(4), r);
    spi_byte(8'h00, r);
    check("R2 reserved top bit dropped", 32'(r), 32'(ID_EXP));
    cs_high();
  endtask

  task automatic t_append();
    logic [31:0] v;
    wr_reg(1, 3, 32'h180060);
    push(24'h0F0F0F, 4'h7, 1'b0, 1'b0);
    rd_reg(3, 4, v); check("R8 data plus status", v, 32'h0F0F0F07);
    rd_reg(0, 1, v); check("R8 ready after long read", v, 32'h87);
    rd_reg(2, 3, v); check("R8 other reads unchanged", v, 32'h000005);
    wr_reg(1, 3, 32'h080060);
  endtask

  task automatic t_parity();
    logic [31:0] v;
    wr_reg(1, 3, 32'h082060);
    push(24'h000007, 4'h0, 1'b0, 1'b0);
    rd_reg(0, 1, v); check("R9 odd ones", v, 32'h10);
    push(24'h000003, 4'h0, 1'b0, 1'b0);
    rd_reg(0, 1, v); check("R9 even ones", v, 32'h00);
    push(24'h800000, 4'h0, 1'b0, 1'b0);
    rd_reg(0, 1, v); check("R9 single top bit", v, 32'h10);
    wr_reg(1, 3, 32'h080060);
    rd_reg(0, 1, v); check("R9 disabled reads zero", v, 32'h00);
  endtask

  task automatic t_cal_gate();
    logic [31:0] v;
    wr_reg(6, 3, 32'h123456);
    rd_reg(6, 3, v); check("R10 offset blocked running", v, 32'h800000);
    wr_reg(1, 3, 32'h480060);
    wr_reg(6, 3, 32'h123456);
    rd_reg(6, 3, v); check("R10 offset idle", v, 32'h123456);
    wr_reg(7, 3, 32'hABCDEF);
    rd_reg(7, 3, v); check("R10 gain idle", v, 32'hABCDEF);
    wr_reg(1, 3, 32'h680060);
    wr_reg(7, 3, 32'h00FF00);
    rd_reg(7, 3, v); check("R10 gain sleep", v, 32'h00FF00);
    wr_reg(1, 3, 32'h280060);
    check("R10 mode port", 32'(mode_word), 32'h280060);
    wr_reg(7, 3, 32'h777777);
    rd_reg(7, 3, v); check("R10 gain blocked single", v, 32'h00FF00);
  endtask

  task automatic t_read_only();
    logic [31:0] v;
    wr_reg(0, 1, 32'hFF);
    rd_reg(0, 1, v); check("R13 status write ignored", v, 32'h00);
    wr_reg(3, 3, 32'hFFFFFF);
    rd_reg(3, 3, v); check("R13 data write ignored", v, 32'h800000);
    wr_reg(4, 1, 32'hFF);
    rd_reg(4, 1, v); check("R13 ident write ignored", v, 32'(ID_EXP));
  endtask

  task automatic t_pins();
    logic [31:0] v;
    gpio_in = 4'b0101;
    wr_reg(5, 1, 32'h3A);
    check("R11 both pairs oe", 32'(gpio_oe), 32'hF);
    check("R11 out levels", 32'(gpio_out), 32'hA);
    check("R11 bridge off", 32'(bridge_sw), 0);
    rd_reg(5, 1, v); check("R11 pin readback", v, 32'h35);
    wr_reg(5, 1, 32'h6C);
    check("R11 upper pair oe", 32'(gpio_oe), 32'hC);
    check("R11 bridge on", 32'(bridge_sw), 1);
    rd_reg(5, 1, v); check("R11 mixed readback", v, 32'h64);
    wr_reg(5, 1, 32'h81);
    rd_reg(5, 1, v); check("R11 top bit reads zero", v, 32'h01);
    check("R11 disabled oe", 32'(gpio_oe), 0);
  endtask

  task automatic t_abort_write();
    logic [31:0] v;
    logic [7:0] r;
    wr_reg(1, 3, 32'h480060);
    wr_reg(7, 3, 32'h111111);
    cs_low();
    spi_byte(wcmd(7), r);
    spi_byte(8'h22, r);
    spi_byte(8'h22, r);
    cs_high();
    rd_reg(7, 3, v); check("R12 partial write dropped", v, 32'h111111);
  endtask

  initial begin
    #(150000*CLK_PERIOD);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5*CLK_PERIOD);
    @(posedge clk); #2;
    rst_n = 1'b1;
    #(5*CLK_PERIOD);
    t_reset();
    t_ready_pin();
    t_abort_read();
    t_backpressure();
    t_bad_cmd();
    t_append();
    t_parity();
    t_cal_gate();
    t_read_only();
    t_pins();
    t_abort_write();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule